// File: doc/BRIEF.md
# Serial-Bus Regulator Control Register File

This block is the control plane for a bank of nine voltage regulators. It is a slave on a two-wire serial bus (I2C, 7-bit addressing) and holds the settings the analog side uses: a voltage code for each regulator, an on/off bit for each regulator and a discharge-when-off bit for each regulator. It also offers a read-only status byte built from three charger inputs and a thermal-OK input. Both bus lines are oversampled by the system clock. SDA is open-drain: the block only ever pulls it low, through `sda_oe`.

A host sets the target register with a write phase. It then writes one data byte, or it issues a repeated START and reads one byte back. The register pointer is kept across STOP conditions and never advances by itself. Bit 7 of register 0 is a power-up marker. Hardware sets it whenever defaults are loaded, and the host can only clear it, so a host that finds it at 1 again knows the block was reset behind its back. Power-good low forces every register back to its default. The core and pad default codes come from two strap pins, which are read only while power-good is low.

Bus engine states: IDLE (bus free), DEVADR (shifting the device address), DEVACK (acknowledge of the address), REGADR (shifting the register index), REGACK, WRDAT (shifting write data), WRACK, RDDAT (driving read data), RDACK (sampling the master's acknowledge) and SKIP (not addressed, waiting for the next START or STOP). Transitions:
- A START moves every state to DEVADR, and a STOP moves every state to IDLE.
- DEVADR goes to DEVACK on an address hit, or to SKIP on a miss.
- DEVACK goes to RDDAT for a read, or to REGADR for a write.
- REGADR goes to REGACK, and REGACK goes to WRDAT.
- WRDAT goes to WRACK, and WRACK goes back to WRDAT.
- RDDAT goes to RDACK.
- RDACK goes back to RDDAT on an ACK, or to SKIP on a NACK.

Each of these moves happens on a falling SCL edge, except START and STOP.

Top module: `i2c_ldo_regfile`

## Requirements
- R1: While power-good is low and after it rises, the outputs hold the defaults listed here.
  - Enables are 9'h017 (bit order 0 pad, 1 core, 2 ana, 3 cam, 4 tcxo, 5 pll, 6 tx, 7 rx, 8 mot).
  - Discharge bits are all 1.
  - Codes: cam 9, mot 1, ana 1, and tcxo, rx, pll and tx each 6.
  - The pad code is 9, or 25 when `strap_pad_hi` is set.
  - The core code is 0, or 9 when `strap_core_hi` is set.
  - Register 0 bit 7 is 1.
- R2: A write (START, address+W, register index, data, STOP) is acknowledged on every byte and stores the data byte in the indexed register. The change shows on the outputs.
- R3: A read (address+W, index, repeated START, address+R, one byte, NACK, STOP) returns the indexed register. The index survives a STOP and any traffic to other slave addresses.
- R4: A device address other than `SLAVE_ADDR`, including the general call address 0, gets no acknowledge and changes no register.
- R5: Register 0 is {flag, 2'b00, pad code[4:0]}. Writing the flag as 1 leaves it unchanged, writing it as 0 clears it, and the pad code field is written in both cases.
- R6: Register 7 holds the enables for bits 7:0. Register 2 is {mot enable, mot discharge, 0, mot code[4:0]}. Writing an enable leaves every voltage code unchanged.
- R7: Register 9 reads {4'b0, therm_ok, fault_n, charging_n, chg_present_n}. Writes to it are acknowledged and ignored.
- R8: Indices 10 to 255 read as 0x00. Writes to them are acknowledged and ignored.
- R9: Power-good low reloads every register with its defaults, even in the middle of a transaction. A strap change while power-good is high has no effect.
- R10: There is no auto-increment. A second data byte in one write goes to the same register, and a second read byte (after a master ACK) repeats the same register.
- R11: Register 1 is {0, core code}, register 3 is {0, cam code}, register 4 is {0, tcxo[5:3], rx[2:0]}, register 5 is {0, pll[5:3], tx[2:0]} and register 6 is {0, ana[2:0]}. Register 8 holds the discharge bits 7:0, in the same order as the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| pwr_good | input | 1 | Low reloads all defaults and idles the bus engine |
| strap_core_hi | input | 1 | Selects the higher core default code |
| strap_pad_hi | input | 1 | Selects the higher pad default code |
| chg_present_n | input | 1 | Charger-present input, reported in status bit 0 |
| charging_n | input | 1 | Charging input, reported in status bit 1 |
| fault_n | input | 1 | Charger fault input, reported in status bit 2 |
| therm_ok | input | 1 | Thermal flag (1 = OK), reported in status bit 3 |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| ldo_en | output | 9 | Regulator enables |
| dis_en | output | 9 | Discharge-when-off enables |
| dig_code | output | 20 | 5-bit codes, {mot, cam, core, pad} |
| ana_code | output | 15 | 3-bit codes, {tx, pll, rx, tcxo, ana} |

## Verification
The case that most needs care is a register store and a power-good drop landing together. Reloading defaults must win over the store that the bus engine is about to make. The bench provokes this by pulling power-good low while the data byte of an enable write is still being clocked in. It then restores power-good, and the case is judged by the enable and discharge outputs reading back their default values, not the written ones. A second overlap is the flag write: one data byte both sets the flag bit to 1, which must be refused, and changes the pad code, which must be accepted.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DEVADR, S_DEVACK, S_REGADR, S_REGACK,
        S_WRDAT, S_WRACK, S_RDDAT, S_RDACK, S_SKIP
    } bus_st_t;

    localparam int N_LDO = 9;
    localparam int N_DIG = 4;
    localparam int N_ANA = 5;
    localparam int DIG_W = 5;
    localparam int ANA_W = 3;

    localparam logic [7:0] A_PAD  = 8'd0;
    localparam logic [7:0] A_CORE = 8'd1;
    localparam logic [7:0] A_MOT  = 8'd2;
    localparam logic [7:0] A_CAM  = 8'd3;
    localparam logic [7:0] A_TR   = 8'd4;
    localparam logic [7:0] A_PT   = 8'd5;
    localparam logic [7:0] A_ANA  = 8'd6;
    localparam logic [7:0] A_EN   = 8'd7;
    localparam logic [7:0] A_DIS  = 8'd8;
    localparam logic [7:0] A_STAT = 8'd9;

    localparam logic [DIG_W-1:0] DEF_PAD_LO  = 5'd9;
    localparam logic [DIG_W-1:0] DEF_PAD_HI  = 5'd25;
    localparam logic [DIG_W-1:0] DEF_CORE_LO = 5'd0;
    localparam logic [DIG_W-1:0] DEF_CORE_HI = 5'd9;
    localparam logic [DIG_W-1:0] DEF_CAM     = 5'd9;
    localparam logic [DIG_W-1:0] DEF_MOT     = 5'd1;
    localparam logic [ANA_W-1:0] DEF_ANA     = 3'd1;
    localparam logic [ANA_W-1:0] DEF_RF      = 3'd6;
    localparam logic [N_LDO-1:0] DEF_EN      = 9'h017;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_sh;
    logic [STAGES:0] sda_sh;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh[g] <= 1'b1;
                    sda_sh[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_sh[g] <= scl_i;
                    sda_sh[g] <= sda_i;
                end else begin
                    scl_sh[g] <= scl_sh[g-1];
                    sda_sh[g] <= sda_sh[g-1];
                end
            end
        end
    endgenerate

    logic scl_p, sda_p;
    assign scl_q     = scl_sh[STAGES-1];
    assign sda_q     = sda_sh[STAGES-1];
    assign scl_p     = scl_sh[STAGES];
    assign sda_p     = sda_sh[STAGES];
    assign scl_rise  = scl_q & ~scl_p;
    assign scl_fall  = ~scl_q & scl_p;
    assign start_det = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2cr_bus_fsm.sv
module i2cr_bus_fsm import i2cr_pkg::*; #(
    parameter logic [6:0] SLAVE_ADDR = 7'b0001000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       scl_q,
    input  logic       sda_q,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_data,
    output logic [7:0] ptr
);
    bus_st_t    state, nxt;
    logic [3:0] cnt;
    logic [7:0] shreg, obuf;
    logic       rw, m_ack;
    logic       addr_hit, byte_done;

    assign addr_hit  = (shreg[7:1] == SLAVE_ADDR) && (shreg[7:1] != 7'd0);
    assign byte_done = scl_fall && (cnt == 4'd8);

    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = S_DEVADR;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_DEVADR: if (byte_done) nxt = addr_hit ? S_DEVACK : S_SKIP;
                S_DEVACK: if (scl_fall)  nxt = rw ? S_RDDAT : S_REGADR;
                S_REGADR: if (byte_done) nxt = S_REGACK;
                S_REGACK: if (scl_fall)  nxt = S_WRDAT;
                S_WRDAT:  if (byte_done) nxt = S_WRACK;
                S_WRACK:  if (scl_fall)  nxt = S_WRDAT;
                S_RDDAT:  if (byte_done) nxt = S_RDACK;
                S_RDACK:  if (scl_fall)  nxt = m_ack ? S_RDDAT : S_SKIP;
                S_IDLE, S_SKIP: nxt = state;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= S_IDLE;
        else if (clr) state <= S_IDLE;
        else          state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; shreg <= '0; obuf <= '0; rw <= 1'b0; m_ack <= 1'b0;
            sda_oe <= 1'b0; wr_stb <= 1'b0; wr_data <= '0; ptr <= '0;
        end else if (clr) begin
            cnt <= '0; shreg <= '0; obuf <= '0; rw <= 1'b0; m_ack <= 1'b0;
            sda_oe <= 1'b0; wr_stb <= 1'b0; wr_data <= '0; ptr <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                sda_oe <= 1'b0;
            end else begin
                if (scl_rise && cnt < 4'd8 &&
                    (state == S_DEVADR || state == S_REGADR ||
                     state == S_WRDAT  || state == S_RDDAT)) begin
                    shreg <= {shreg[6:0], sda_q};
                    cnt   <= cnt + 4'd1;
                end
                if (scl_rise && state == S_RDACK) m_ack <= ~sda_q;
                if (scl_fall) begin
                    unique case (state)
                        S_DEVADR: if (cnt == 4'd8) begin
                            sda_oe <= addr_hit;
                            rw     <= shreg[0];
                        end
                        S_DEVACK: begin
                            obuf   <= rd_data;
                            sda_oe <= rw & ~rd_data[7];
                            cnt    <= '0;
                        end
                        S_REGADR: if (cnt == 4'd8) begin
                            ptr    <= shreg;
                            sda_oe <= 1'b1;
                        end
                        S_WRDAT: if (cnt == 4'd8) begin
                            wr_stb  <= 1'b1;
                            wr_data <= shreg;
                            sda_oe  <= 1'b1;
                        end
                        S_REGACK, S_WRACK: begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                        end
                        S_RDDAT: begin
                            if (cnt == 4'd8) sda_oe <= 1'b0;
                            else             sda_oe <= ~obuf[3'(4'd7 - cnt)];
                        end
                        S_RDACK: begin
                            if (m_ack) begin
                                obuf   <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        S_IDLE, S_SKIP: sda_oe <= 1'b0;
                        default: sda_oe <= 1'b0;
                    endcase
                end
            end
        end
    end

    // R4
    quiet_when_unaddressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_SKIP) |-> !sda_oe);

    // R2
    sda_moves_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !$stable(sda_oe) |-> !scl_q);
endmodule

// File: rtl/i2cr_regbank.sv
module i2cr_regbank import i2cr_pkg::*; (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     strap_core_hi,
    input  logic                     strap_pad_hi,
    input  logic                     wr_stb,
    input  logic [7:0]               wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [7:0]               rd_addr,
    input  logic [3:0]               stat_in,
    output logic [7:0]               rd_data,
    output logic [N_LDO-1:0]         en_o,
    output logic [N_LDO-1:0]         dis_o,
    output logic [N_DIG*DIG_W-1:0]   dig_o,
    output logic [N_ANA*ANA_W-1:0]   ana_o
);
    logic                 dsb_q;
    logic [DIG_W-1:0]     pad_q, core_q, cam_q, mot_q;
    logic [ANA_W-1:0]     ana_q, tcxo_q, rx_q, pll_q, tx_q;
    logic [N_LDO-1:0]     en_q, dis_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsb_q <= 1'b1; pad_q <= DEF_PAD_LO; core_q <= DEF_CORE_LO;
            cam_q <= DEF_CAM; mot_q <= DEF_MOT; ana_q <= DEF_ANA;
            tcxo_q <= DEF_RF; rx_q <= DEF_RF; pll_q <= DEF_RF; tx_q <= DEF_RF;
            en_q <= DEF_EN; dis_q <= '1;
        end else if (clr) begin
            dsb_q  <= 1'b1;
            pad_q  <= strap_pad_hi  ? DEF_PAD_HI  : DEF_PAD_LO;
            core_q <= strap_core_hi ? DEF_CORE_HI : DEF_CORE_LO;
            cam_q <= DEF_CAM; mot_q <= DEF_MOT; ana_q <= DEF_ANA;
            tcxo_q <= DEF_RF; rx_q <= DEF_RF; pll_q <= DEF_RF; tx_q <= DEF_RF;
            en_q <= DEF_EN; dis_q <= '1;
        end else if (wr_stb) begin
            case (wr_addr)
                A_PAD: begin
                    dsb_q <= dsb_q & wr_data[7];
                    pad_q <= wr_data[4:0];
                end
                A_CORE: core_q <= wr_data[4:0];
                A_MOT: begin
                    en_q[8]  <= wr_data[7];
                    dis_q[8] <= wr_data[6];
                    mot_q    <= wr_data[4:0];
                end
                A_CAM: cam_q <= wr_data[4:0];
                A_TR:  begin tcxo_q <= wr_data[5:3]; rx_q <= wr_data[2:0]; end
                A_PT:  begin pll_q  <= wr_data[5:3]; tx_q <= wr_data[2:0]; end
                A_ANA: ana_q <= wr_data[2:0];
                A_EN:  en_q[7:0]  <= wr_data;
                A_DIS: dis_q[7:0] <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_PAD:  rd_data = {dsb_q, 2'b00, pad_q};
            A_CORE: rd_data = {3'b000, core_q};
            A_MOT:  rd_data = {en_q[8], dis_q[8], 1'b0, mot_q};
            A_CAM:  rd_data = {3'b000, cam_q};
            A_TR:   rd_data = {2'b00, tcxo_q, rx_q};
            A_PT:   rd_data = {2'b00, pll_q, tx_q};
            A_ANA:  rd_data = {5'b00000, ana_q};
            A_EN:   rd_data = en_q[7:0];
            A_DIS:  rd_data = dis_q[7:0];
            A_STAT: rd_data = {4'b0000, stat_in};
            default: rd_data = 8'h00;
        endcase
    end

    assign en_o  = en_q;
    assign dis_o = dis_q;
    assign dig_o = {mot_q, cam_q, core_q, pad_q};
    assign ana_o = {tx_q, pll_q, rx_q, tcxo_q, ana_q};

    // R5
    flag_never_set_by_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && $past(!clr)) |-> !$rose(dsb_q));

    // R9
    clear_restores_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dis_o == '1));

    // R6
    enable_write_keeps_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !clr && wr_addr == A_EN) |=> ($stable(dig_o) && $stable(ana_o)));

    // R7
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_STAT) |-> (rd_data[7:4] == 4'h0));
endmodule

// File: rtl/i2c_ldo_regfile.sv
module i2c_ldo_regfile import i2cr_pkg::*; #(
    parameter logic [6:0] SLAVE_ADDR  = 7'b0001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_good,
    input  logic                   strap_core_hi,
    input  logic                   strap_pad_hi,
    input  logic                   chg_present_n,
    input  logic                   charging_n,
    input  logic                   fault_n,
    input  logic                   therm_ok,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [N_LDO-1:0]       ldo_en,
    output logic [N_LDO-1:0]       dis_en,
    output logic [N_DIG*DIG_W-1:0] dig_code,
    output logic [N_ANA*ANA_W-1:0] ana_code
);
    logic       clr;
    logic       scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb;
    logic [7:0] wr_data, ptr, rd_data;

    assign clr = ~pwr_good;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cr_bus_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .scl_q(scl_q), .sda_q(sda_q),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_data(rd_data), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_data(wr_data), .ptr(ptr)
    );

    i2cr_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .strap_core_hi(strap_core_hi), .strap_pad_hi(strap_pad_hi),
        .wr_stb(wr_stb), .wr_addr(ptr), .wr_data(wr_data), .rd_addr(ptr),
        .stat_in({therm_ok, fault_n, charging_n, chg_present_n}),
        .rd_data(rd_data), .en_o(ldo_en), .dis_o(dis_en),
        .dig_o(dig_code), .ana_o(ana_code)
    );
endmodule

// File: tb/i2c_ldo_regfile_test.sv
module i2c_ldo_regfile_test;
    localparam logic [6:0] ADDR = 7'b0001000;
    localparam int Q = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, pwr_good = 1'b0, strap_core_hi = 1'b0, strap_pad_hi = 1'b0;
    logic chg_present_n = 1'b1, charging_n = 1'b0, fault_n = 1'b1, therm_ok = 1'b1;
    logic scl = 1'b1, msda = 1'b1;
    logic sda_oe, sda_line;
    logic [8:0] ldo_en, dis_en;
    logic [19:0] dig_code;
    logic [14:0] ana_code;

    assign sda_line = msda & ~sda_oe;

    i2c_ldo_regfile #(.SLAVE_ADDR(ADDR)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .strap_core_hi(strap_core_hi), .strap_pad_hi(strap_pad_hi),
        .chg_present_n(chg_present_n), .charging_n(charging_n),
        .fault_n(fault_n), .therm_ok(therm_ok),
        .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .ldo_en(ldo_en), .dis_en(dis_en), .dig_code(dig_code), .ana_code(ana_code)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        msda = 1'b1; qw(); scl = 1'b1; qw(); msda = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        msda = 1'b0; qw(); scl = 1'b1; qw(); msda = 1'b1; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
        msda = 1'b1; qw(); scl = 1'b1; qw(); acked = ~sda_line; qw(); scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            msda = 1'b1; qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
        end
        msda = give_ack ? 1'b0 : 1'b1; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic reg_write(input logic [7:0] ra, input logic [7:0] d, input bit chk_ack);
        bit a0, a1, a2;
        bus_start();
        send_byte({ADDR, 1'b0}, a0);
        send_byte(ra, a1);
        send_byte(d, a2);
        bus_stop();
        if (chk_ack) chk(a0 && a1 && a2, "R2 ack on every write byte", {a0, a1, a2}, 3'b111);
    endtask

    task automatic reg_read(input logic [7:0] ra, output logic [7:0] d);
        bit a;
        bus_start();
        send_byte({ADDR, 1'b0}, a);
        send_byte(ra, a);
        bus_start();
        send_byte({ADDR, 1'b1}, a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    function automatic logic [4:0] dg(input int i); return dig_code[i*5 +: 5]; endfunction
    function automatic logic [2:0] an(input int i); return ana_code[i*3 +: 3]; endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [19:0] dsave;
        logic [14:0] asave;
        bit a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 defaults while power-good low
        chk(ldo_en == 9'h017, "R1 enables at power-up", ldo_en, 9'h017);
        pwr_good = 1'b1;
        repeat (5) @(negedge clk);
        chk(dis_en == 9'h1FF, "R1 discharge default", dis_en, 9'h1FF);
        chk(dig_code == {5'd1, 5'd9, 5'd0, 5'd9}, "R1 digital codes", dig_code, {5'd1, 5'd9, 5'd0, 5'd9});
        chk(ana_code == {3'd6, 3'd6, 3'd6, 3'd6, 3'd1}, "R1 analog codes", ana_code, {3'd6, 3'd6, 3'd6, 3'd6, 3'd1});
        reg_read(8'd0, rd);
        chk(rd == 8'h89, "R1 flag and pad code readback", rd, 8'h89);

        // R5 flag write-1 ignored, pad field written
        reg_write(8'd0, 8'h91, 1'b1);
        reg_read(8'd0, rd);
        chk(rd == 8'h91, "R5 write with flag=1", rd, 8'h91);
        reg_write(8'd0, 8'h05, 1'b1);
        reg_read(8'd0, rd);
        chk(rd == 8'h05, "R5 flag cleared", rd, 8'h05);
        reg_write(8'd0, 8'h85, 1'b1);
        reg_read(8'd0, rd);
        chk(rd == 8'h05, "R5 flag cannot be set", rd, 8'h05);
        chk(dg(0) == 5'd5, "R5 pad code output", dg(0), 5);

        // R2 sweep of every core code
        for (int k = 0; k < 32; k++) begin
            reg_write(8'd1, 8'(k), 1'b1);
            repeat (4) @(negedge clk);
            chk(dg(1) == 5'(k), "R2 core code sweep", dg(1), k);
        end
        reg_read(8'd1, rd);
        chk(rd == 8'h1F, "R11 core register layout", rd, 8'h1F);

        // R11 packed analog fields sweep
        for (int k = 0; k < 8; k++) begin
            reg_write(8'd4, 8'((k << 3) | (7 - k)), 1'b1);
            repeat (4) @(negedge clk);
            chk(an(1) == 3'(k) && an(2) == 3'(7 - k), "R11 tcxo/rx packing",
                {an(1), an(2)}, (k << 3) | (7 - k));
        end
        reg_write(8'd5, 8'h2B, 1'b1);
        reg_write(8'd6, 8'h04, 1'b1);
        reg_write(8'd3, 8'h13, 1'b1);
        repeat (4) @(negedge clk);
        chk(an(3) == 3'd5 && an(4) == 3'd3, "R11 pll/tx packing", {an(3), an(4)}, 6'h2B);
        chk(an(0) == 3'd4, "R11 ana code", an(0), 4);
        chk(dg(2) == 5'h13, "R11 cam code", dg(2), 5'h13);
        reg_write(8'd2, 8'h94, 1'b1);
        repeat (4) @(negedge clk);
        chk(ldo_en[8] == 1'b1 && dis_en[8] == 1'b0 && dg(3) == 5'h14, "R6 motor register",
            {ldo_en[8], dis_en[8], dg(3)}, {1'b1, 1'b0, 5'h14});

        // R6 enable toggles keep codes
        dsave = dig_code; asave = ana_code;
        reg_write(8'd7, 8'hA5, 1'b1);
        repeat (4) @(negedge clk);
        chk(ldo_en[7:0] == 8'hA5, "R6 enable write", ldo_en[7:0], 8'hA5);
        reg_write(8'd7, 8'h5A, 1'b1);
        repeat (4) @(negedge clk);
        chk(ldo_en[7:0] == 8'h5A && dig_code == dsave && ana_code == asave,
            "R6 codes unchanged by enables", dig_code, dsave);
        reg_write(8'd8, 8'h3C, 1'b1);
        repeat (4) @(negedge clk);
        chk(dis_en[7:0] == 8'h3C, "R11 discharge register", dis_en[7:0], 8'h3C);

        // R7 status read-only
        reg_read(8'd9, rd);
        chk(rd == 8'h0D, "R7 status reflects inputs", rd, 8'h0D);
        chk_in: begin
            chg_present_n = 1'b0; charging_n = 1'b1; fault_n = 1'b0; therm_ok = 1'b0;
        end
        reg_write(8'd9, 8'hFF, 1'b1);
        reg_read(8'd9, rd);
        chk(rd == 8'h02, "R7 status write ignored", rd, 8'h02);

        // R8 unimplemented addresses
        dsave = dig_code;
        reg_write(8'h20, 8'hAA, 1'b1);
        reg_read(8'h20, rd);
        chk(rd == 8'h00, "R8 unimplemented reads zero", rd, 0);
        reg_read(8'h0A, rd);
        chk(rd == 8'h00 && dig_code == dsave, "R8 no side effect", rd, 0);

        // R3/R4 pointer survives stop and foreign traffic
        bus_start(); send_byte({ADDR, 1'b0}, a); send_byte(8'd1, a); bus_stop();
        bus_start(); send_byte({7'h50, 1'b0}, a); bus_stop();
        chk(!a, "R4 foreign address not acked", a, 0);
        bus_start(); send_byte(8'h00, a); bus_stop();
        chk(!a, "R4 general call not acked", a, 0);
        bus_start(); send_byte({ADDR, 1'b1}, a); recv_byte(1'b0, rd); bus_stop();
        chk(a && rd == 8'h1F, "R3 pointer persists across stop", rd, 8'h1F);

        // R10 no auto-increment
        bus_start(); send_byte({ADDR, 1'b0}, a); send_byte(8'd3, a);
        send_byte(8'h0A, a); send_byte(8'h0C, a); bus_stop();
        repeat (4) @(negedge clk);
        chk(dg(2) == 5'h0C && an(1) == 3'd7 && an(2) == 3'd0, "R10 second byte same register",
            dg(2), 5'h0C);
        begin
            logic [7:0] r0, r1;
            bus_start(); send_byte({ADDR, 1'b1}, a);
            recv_byte(1'b1, r0); recv_byte(1'b0, r1); bus_stop();
            chk(r0 == 8'h0C && r1 == 8'h0C, "R10 repeated read same register", {r0, r1}, 16'h0C0C);
        end

        // R9 power-good drop overlapping a write
        fork
            reg_write(8'd7, 8'h00, 1'b0);
            begin
                repeat (560) @(negedge clk);
                pwr_good = 1'b0;
                repeat (400) @(negedge clk);
            end
        join
        pwr_good = 1'b1;
        repeat (5) @(negedge clk);
        chk(ldo_en == 9'h017 && dis_en == 9'h1FF, "R9 reset wins over write", ldo_en, 9'h017);

        // R9 straps sampled only with power-good low
        strap_core_hi = 1'b1; strap_pad_hi = 1'b1;
        pwr_good = 1'b0; repeat (5) @(negedge clk); pwr_good = 1'b1;
        repeat (5) @(negedge clk);
        strap_core_hi = 1'b0; strap_pad_hi = 1'b0;
        repeat (5) @(negedge clk);
        chk(dg(0) == 5'd25 && dg(1) == 5'd9, "R9 strap defaults latched", {dg(0), dg(1)}, {5'd25, 5'd9});
        reg_read(8'd0, rd);
        chk(rd == 8'h99, "R1 flag set again after reload", rd, 8'h99);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule